// File: doc/BRIEF.md
# Pixel Colour Matrix Transform

This block converts one pixel per clock from one colour space to another on an overlay pixel stream. Each pixel carries three 10-bit unsigned components. The first step adds a signed offset to each component. The second step multiplies the three-component vector by a programmable 3x3 matrix of signed fixed-point coefficients. The third step rounds each row sum, adds a signed offset after the matrix, and clamps the result to the 10-bit range. A typical setup converts full-range RGB into limited-range YUV. For that case the post-offsets are 64, 512 and 512.

Software loads the pre-offsets, coefficients and post-offsets through a write-only port of 32-bit words. A single control bit selects between two modes: apply the transform, or pass the pixel through untouched. Both modes have the same latency, so switching modes never changes the timing of the stream. Configuration is meant to be changed while no pixels are in flight.

Top module: `csc_matrix_top`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `out_valid` is 0 and `out_pix` is 0. Reset also clears every configuration field, so the block starts in pass-through mode.
- R2: A pixel presented with `in_valid` high in cycle n appears with `out_valid` high in cycle n+3. Any cycle with `in_valid` low produces a cycle with `out_valid` low three cycles later. This holds in both modes.
- R3: Register 0 bit 0 is the enable bit, and all other bits of register 0 are ignored. When the enable bit is 0, `out_pix` equals the input pixel bit for bit, whatever the loaded coefficients and offsets are.
- R4: Component i of a pixel sits in `in_pix`/`out_pix` bits [10i+9:10i]. There are three pre-offsets, each 12-bit two's complement. Offset k lives in register 1+k/2, in bits 27:16 when k is even and in bits 11:0 when k is odd. Each one is added to its zero-extended input component before the multiply.
- R5: There are nine coefficients, each 13-bit two's complement with 10 fractional bits, so 1024 means 1.0. Coefficient k = 3*row+col lives in register 3+k/2, in bits 28:16 when k is even and in bits 12:0 when k is odd. This gives the pairs 00/01, 02/10, 11/12, 20/21, and then 22 alone in the upper half. Output row r is the sum over col of coef[r][col] times offset input[col].
- R6: Each row sum has 512 added to it and is then shifted right arithmetically by 10 bits. Halves therefore round towards plus infinity.
- R7: There are three post-offsets, each 12-bit two's complement, in registers 8 and 9. They use the same half-word layout as the pre-offsets. Each one is added to its rounded row result.
- R8: The result after the post-offset is clamped to the range 0 to 1023.
- R9: Writes to addresses 10 to 15 change no configuration.
- R10: While `out_valid` is low, `out_pix` keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Configuration write strobe |
| wr_addr | input | 4 | Configuration word address |
| wr_data | input | 32 | Configuration word |
| in_valid | input | 1 | Input pixel qualifier |
| in_pix | input | 30 | Input pixel, three 10-bit components |
| out_valid | output | 1 | Output pixel qualifier |
| out_pix | output | 30 | Output pixel, three 10-bit components |

## Verification
A pixel driven in cycle n is due at the outputs in cycle n+3. The bench drives stimulus just after a falling edge and reads results at later falling edges. In the single-pixel tests it checks `out_valid` low at the first and second falling edges, then data at the third, and then confirms the value is held at the fourth. Streamed vectors are sent back to back and matched in order against a table of hand-computed results. Configuration writes complete one edge before the first pixel that depends on them.

// File: rtl/csc_pkg.sv
package csc_pkg;

    localparam int COMP_W  = 10;
    localparam int N_COMP  = 3;
    localparam int COEF_W  = 13;
    localparam int OFF_W   = 12;
    localparam int FRAC_W  = 10;
    localparam int ADDR_W  = 4;
    localparam int DATA_W  = 32;
    localparam int HI_LSB  = 16;

    localparam int N_COEF       = N_COMP * N_COMP;
    localparam int PIX_W        = COMP_W * N_COMP;
    localparam int N_OFF_WORDS  = (N_COMP + 1) / 2;
    localparam int N_COEF_WORDS = (N_COEF + 1) / 2;
    localparam int A_CTRL       = 0;
    localparam int A_PRE        = 1;
    localparam int A_COEF       = A_PRE + N_OFF_WORDS;
    localparam int A_POST       = A_COEF + N_COEF_WORDS;
    localparam int A_LAST       = A_POST + N_OFF_WORDS - 1;

    localparam int A_W     = ((COMP_W + 1) > OFF_W ? (COMP_W + 1) : OFF_W) + 1;
    localparam int PROD_W  = A_W + COEF_W;
    localparam int SUM_W   = PROD_W + $clog2(N_COMP);
    localparam int RND_W   = SUM_W + 1;
    localparam int SH_W    = RND_W - FRAC_W;
    localparam int RES_W   = (SH_W > OFF_W ? SH_W : OFF_W) + 1;
    localparam int COMP_MAX = (1 << COMP_W) - 1;

    typedef logic [COMP_W-1:0]        comp_t;
    typedef logic signed [COEF_W-1:0] coef_t;
    typedef logic signed [OFF_W-1:0]  offset_t;
    typedef logic signed [A_W-1:0]    adj_t;
    typedef logic signed [SUM_W-1:0]  sum_t;
    typedef logic signed [SH_W-1:0]   shifted_t;
    typedef logic signed [RES_W-1:0]  res_t;

    typedef struct packed {
        logic                      en;
        offset_t [N_COMP-1:0]      pre;
        coef_t   [N_COEF-1:0]      coef;
        offset_t [N_COMP-1:0]      post;
    } cfg_t;

    typedef struct packed {
        logic                 vld;
        logic                 en;
        comp_t [N_COMP-1:0]   raw;
        adj_t  [N_COMP-1:0]   adj;
    } s1_t;

    typedef struct packed {
        logic                 vld;
        logic                 en;
        comp_t [N_COMP-1:0]   raw;
        sum_t  [N_COMP-1:0]   sum;
    } s2_t;

    function automatic shifted_t round_shift(input sum_t s);
        logic signed [RND_W-1:0] r;
        r = RND_W'(s);
        r = r + RND_W'(1 << (FRAC_W - 1));
        return SH_W'(r >>> FRAC_W);
    endfunction

    function automatic comp_t clamp_comp(input res_t v);
        if (v < 0)
            return '0;
        else if (v > RES_W'(COMP_MAX))
            return '1;
        else
            return v[COMP_W-1:0];
    endfunction

endpackage

// File: rtl/csc_cfg_regs.sv
module csc_cfg_regs
    import csc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output cfg_t              cfg
);

    logic unused_bits;
    assign unused_bits = ^{wr_data[DATA_W-1:HI_LSB+COEF_W], wr_data[HI_LSB-1:COEF_W]};

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (wr_en) begin
            if (wr_addr == ADDR_W'(A_CTRL))
                cfg.en <= wr_data[0];
            for (int k = 0; k < N_COMP; k++) begin
                if (wr_addr == ADDR_W'(A_PRE + k / 2))
                    cfg.pre[k] <= (k % 2 == 0) ? wr_data[HI_LSB +: OFF_W] : wr_data[0 +: OFF_W];
                if (wr_addr == ADDR_W'(A_POST + k / 2))
                    cfg.post[k] <= (k % 2 == 0) ? wr_data[HI_LSB +: OFF_W] : wr_data[0 +: OFF_W];
            end
            for (int k = 0; k < N_COEF; k++) begin
                if (wr_addr == ADDR_W'(A_COEF + k / 2))
                    cfg.coef[k] <= (k % 2 == 0) ? wr_data[HI_LSB +: COEF_W] : wr_data[0 +: COEF_W];
            end
        end
    end

endmodule

// File: rtl/csc_pre_stage.sv
module csc_pre_stage
    import csc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  comp_t [N_COMP-1:0]   in_comp,
    input  logic                 en,
    input  offset_t [N_COMP-1:0] pre,
    output s1_t                  s1
);

    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= '0;
        end else begin
            s1.vld <= in_valid;
            if (in_valid) begin
                s1.en  <= en;
                s1.raw <= in_comp;
                for (int i = 0; i < N_COMP; i++)
                    s1.adj[i] <= adj_t'({1'b0, in_comp[i]}) + adj_t'($signed(pre[i]));
            end
        end
    end

endmodule

// File: rtl/csc_mac_stage.sv
module csc_mac_stage
    import csc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  s1_t                s1,
    input  coef_t [N_COEF-1:0] coef,
    output s2_t                s2
);

    sum_t [N_COMP-1:0] row_sum;

    for (genvar r = 0; r < N_COMP; r++) begin : g_row
        sum_t acc;
        always_comb begin
            acc = '0;
            for (int c = 0; c < N_COMP; c++)
                acc = acc + sum_t'($signed(s1.adj[c])) * sum_t'($signed(coef[r*N_COMP+c]));
        end
        assign row_sum[r] = acc;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s2 <= '0;
        end else begin
            s2.vld <= s1.vld;
            if (s1.vld) begin
                s2.en  <= s1.en;
                s2.raw <= s1.raw;
                s2.sum <= row_sum;
            end
        end
    end

endmodule

// File: rtl/csc_out_stage.sv
module csc_out_stage
    import csc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  s2_t                  s2,
    input  offset_t [N_COMP-1:0] post,
    output logic                 out_valid,
    output comp_t [N_COMP-1:0]   out_comp
);

    comp_t [N_COMP-1:0] result;

    for (genvar i = 0; i < N_COMP; i++) begin : g_comp
        shifted_t sh;
        res_t     biased;
        assign sh        = round_shift(s2.sum[i]);
        assign biased    = RES_W'(sh) + RES_W'($signed(post[i]));
        assign result[i] = s2.en ? clamp_comp(biased) : s2.raw[i];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_comp  <= '0;
        end else begin
            out_valid <= s2.vld;
            if (s2.vld)
                out_comp <= result;
        end
    end

endmodule

// File: rtl/csc_matrix_top.sv
module csc_matrix_top
    import csc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              in_valid,
    input  logic [PIX_W-1:0]  in_pix,
    output logic              out_valid,
    output logic [PIX_W-1:0]  out_pix
);

    cfg_t               cfg_q;
    s1_t                s1_q;
    s2_t                s2_q;
    comp_t [N_COMP-1:0] in_comp;
    comp_t [N_COMP-1:0] out_comp;

    assign in_comp = in_pix;
    assign out_pix = out_comp;

    csc_cfg_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .cfg     (cfg_q)
    );

    csc_pre_stage u_pre (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_comp  (in_comp),
        .en       (cfg_q.en),
        .pre      (cfg_q.pre),
        .s1       (s1_q)
    );

    csc_mac_stage u_mac (
        .clk  (clk),
        .rst  (rst),
        .s1   (s1_q),
        .coef (cfg_q.coef),
        .s2   (s2_q)
    );

    csc_out_stage u_out (
        .clk       (clk),
        .rst       (rst),
        .s2        (s2_q),
        .post      (cfg_q.post),
        .out_valid (out_valid),
        .out_comp  (out_comp)
    );

endmodule

// File: rtl/csc_matrix_chk.sv
module csc_matrix_chk
    import csc_pkg::*;
(
    input logic                     clk,
    input logic                     rst,
    input logic                     wr_en,
    input logic [ADDR_W-1:0]        wr_addr,
    input logic                     in_valid,
    input logic [PIX_W-1:0]         in_pix,
    input logic                     out_valid,
    input logic [PIX_W-1:0]         out_pix,
    input logic [$bits(cfg_t)-1:0]  cfg_bits
);

    logic [2:0]       hv;
    logic [2:0]       he;
    logic [PIX_W-1:0] hp [3];
    logic             first;

    always_ff @(posedge clk) begin
        if (rst) begin
            hv    <= '0;
            he    <= '0;
            first <= 1'b1;
            for (int i = 0; i < 3; i++) hp[i] <= '0;
        end else begin
            hv    <= {hv[1:0], in_valid};
            he    <= {he[1:0], cfg_bits[$bits(cfg_t)-1]};
            hp[0] <= in_pix;
            hp[1] <= hp[0];
            hp[2] <= hp[1];
            first <= 1'b0;
        end
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        first |-> (!out_valid && out_pix == '0));

    // R2
    latency_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid == hv[2]);

    // R3
    bypass_chk: assert property (@(posedge clk) disable iff (rst)
        (hv[2] && !he[2]) |-> (out_pix == hp[2]));

    // R9
    unmapped_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr > ADDR_W'(A_LAST)) |=> $stable(cfg_bits));

    // R10
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> $stable(out_pix));

endmodule

bind csc_matrix_top csc_matrix_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .in_valid  (in_valid),
    .in_pix    (in_pix),
    .out_valid (out_valid),
    .out_pix   (out_pix),
    .cfg_bits  (cfg_q)
);

// File: tb/tb_csc_matrix_top.sv
module tb_csc_matrix_top;
    import csc_pkg::*;

    logic              clk = 1'b0;
    logic              rst;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;
    logic              in_valid;
    logic [PIX_W-1:0]  in_pix;
    logic              out_valid;
    logic [PIX_W-1:0]  out_pix;

    int n_cmp = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    csc_matrix_top dut (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .in_valid  (in_valid),
        .in_pix    (in_pix),
        .out_valid (out_valid),
        .out_pix   (out_pix)
    );

    // {group, in2, in1, in0, exp2, exp1, exp0}; group 0 = offset/rounding set, 1 = RGB to limited YUV
    localparam int NV = 10;
    localparam logic [60:0] VEC [NV] = '{
        {1'b0, 10'd1,    10'd1,    10'd50,   10'd597, 10'd601,  10'd0  },
        {1'b0, 10'd0,    10'd3,    10'd1023, 10'd598, 10'd602,  10'd923},
        {1'b0, 10'd1023, 10'd1023, 10'd100,  10'd86,  10'd1023, 10'd0  },
        {1'b0, 10'd20,   10'd2,    10'd600,  10'd588, 10'd601,  10'd500},
        {1'b1, 10'd0,    10'd0,    10'd0,    10'd512, 10'd512,  10'd64 },
        {1'b1, 10'd1023, 10'd1023, 10'd1023, 10'd514, 10'd514,  10'd939},
        {1'b1, 10'd0,    10'd0,    10'd1023, 10'd960, 10'd410,  10'd250},
        {1'b1, 10'd0,    10'd1023, 10'd0,    10'd106, 10'd168,  10'd690},
        {1'b1, 10'd1023, 10'd0,    10'd0,    10'd472, 10'd960,  10'd127},
        {1'b1, 10'd512,  10'd512,  10'd512,  10'd513, 10'd513,  10'd502}
    };

    function automatic logic [PIX_W-1:0] px(input int c0, input int c1, input int c2);
        return {c2[9:0], c1[9:0], c0[9:0]};
    endfunction

    function automatic logic [31:0] pk_off(input int hi, input int lo);
        return {4'h0, hi[11:0], 4'h0, lo[11:0]};
    endfunction

    function automatic logic [31:0] pk_cf(input int hi, input int lo);
        return {3'b0, hi[12:0], 3'b0, lo[12:0]};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic write_reg(input int addr, input logic [31:0] data);
        wr_en   = 1'b1;
        wr_addr = addr[ADDR_W-1:0];
        wr_data = data;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    // one pixel: output due at the third falling edge, then held at the fourth
    task automatic single_lat(input logic [PIX_W-1:0] pin, input logic [PIX_W-1:0] pexp, input string tag);
        in_valid = 1'b1;
        in_pix   = pin;
        @(negedge clk);
        in_valid = 1'b0;
        in_pix   = '0;
        check({tag, " R2 early cycle 1"}, 32'(out_valid), 32'd0);
        @(negedge clk);
        check({tag, " R2 early cycle 2"}, 32'(out_valid), 32'd0);
        @(negedge clk);
        check({tag, " R2 valid at cycle 3"}, 32'(out_valid), 32'd1);
        check({tag, " data"}, 32'(out_pix), 32'(pexp));
        @(negedge clk);
        check({tag, " R10 valid drop"}, 32'(out_valid), 32'd0);
        check({tag, " R10 hold"}, 32'(out_pix), 32'(pexp));
    endtask

    task automatic run_group(input logic grp, input string tag);
        logic [PIX_W-1:0] expq [NV];
        int sent = 0;
        int got  = 0;
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][60] == grp) begin
                in_valid    = 1'b1;
                in_pix      = VEC[i][59:30];
                expq[sent]  = VEC[i][29:0];
                sent++;
                @(negedge clk);
                if (out_valid) begin
                    check(tag, 32'(out_pix), 32'(expq[got]));
                    got++;
                end
            end
        end
        in_valid = 1'b0;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            if (out_valid) begin
                check(tag, 32'(out_pix), 32'(expq[got]));
                got++;
            end
        end
        check({tag, " R2 count"}, 32'(got), 32'(sent));
    endtask

    task automatic report;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL R2 watchdog expired actual=hung expected=done");
        report();
    end

    initial begin
        rst      = 1'b1;
        wr_en    = 1'b0;
        wr_addr  = '0;
        wr_data  = '0;
        in_valid = 1'b0;
        in_pix   = '0;
        repeat (3) @(negedge clk);
        check("R1 valid in reset", 32'(out_valid), 32'd0);
        check("R1 data in reset", 32'(out_pix), 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 valid after reset", 32'(out_valid), 32'd0);
        check("R1 data after reset", 32'(out_pix), 32'd0);

        // R1 R3: default configuration passes pixels through
        single_lat(px(123, 456, 789), px(123, 456, 789), "R1 R3 default bypass");

        // group 0: R4 pre-offsets, R6 rounding, R7 post-offsets, R8 clamp
        write_reg(A_PRE,      pk_off(-200, 0));
        write_reg(A_PRE + 1,  pk_off(5, 0));
        write_reg(A_COEF,     pk_cf(1024, 0));
        write_reg(A_COEF + 1, pk_cf(0, 0));
        write_reg(A_COEF + 2, pk_cf(512, 0));
        write_reg(A_COEF + 3, pk_cf(0, 0));
        write_reg(A_COEF + 4, pk_cf(-512, 0));
        write_reg(A_POST,     pk_off(100, 600));
        write_reg(A_POST + 1, pk_off(600, 0));
        write_reg(A_CTRL,     32'h1);
        run_group(1'b0, "R4/R6/R7/R8 offset-round-clamp");

        // group 1: R5 full coefficient layout, R7 limited-range offsets
        write_reg(A_PRE,      pk_off(0, 0));
        write_reg(A_PRE + 1,  pk_off(0, 0));
        write_reg(A_COEF,     pk_cf(186, 627));
        write_reg(A_COEF + 1, pk_cf(63, -102));
        write_reg(A_COEF + 2, pk_cf(-344, 448));
        write_reg(A_COEF + 3, pk_cf(448, -406));
        write_reg(A_COEF + 4, pk_cf(-40, 0));
        write_reg(A_POST,     pk_off(64, 512));
        write_reg(A_POST + 1, pk_off(512, 0));
        run_group(1'b1, "R5/R7 rgb to yuv");

        // R2 R10: exact latency with transform enabled
        single_lat(px(0, 0, 0), px(64, 512, 512), "R2 R10 enabled black");

        // R9: writes above the map leave the configuration alone
        for (int a = A_LAST + 1; a < (1 << ADDR_W); a++)
            write_reg(a, 32'hFFFF_FFFF);
        single_lat(px(1023, 0, 0), px(250, 410, 960), "R9 unmapped writes");

        // R3: enable clear with other control bits set, coefficients still loaded
        write_reg(A_CTRL, 32'hFFFF_FFFE);
        single_lat(px(123, 456, 789), px(123, 456, 789), "R3 bypass loaded");
        single_lat(px(1023, 0, 1), px(1023, 0, 1), "R3 bypass edge values");

        report();
    end

endmodule